// File: doc/BRIEF.md
# Flash End-of-Write Status Reporter

This block sits on the device side of a flash bank. It decides what the data bus returns during an internally timed program or erase. The command decoder supplies a one-cycle start pulse with an operation kind, a target address and the word to program. The pulse marks the end of the final command write. From the next cycle the block is busy for a fixed number of clock cycles, and that count depends on the kind of operation.

While the block is busy, a qualified read does not return array data. Bit 7 carries a polling flag: the inverse of the pending word's bit 7 for a program, and 0 for an erase. Bit 6 inverts at the start of every new read. When the operation ends, the array is updated. Bit 7 then shows true data straight away, but the full word is only returned after a configurable settle window has passed. The array is a small behavioural register file that resets to the erased value.

Top module: `flash_eow_status`

## Requirements
- R1: After reset, `busy` is 0 and every array word reads as 16'hFFFF.
- R2: A start pulse accepted while idle raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYC cycles for kind 2'b00 (program), ERASE_CYC cycles for kinds 2'b01 (sector erase) and 2'b10 (block erase), and CHIP_CYC cycles for kind 2'b11 (chip erase).
- R3: While a program is busy, bit 7 of every qualified read is the inverse of bit 7 of the word being programmed.
- R4: While any erase is busy, bit 7 of every qualified read is 0.
- R5: A read is qualified only when `bank_en_n` and `out_en_n` are low and `wr_en_n` is high. While busy, bit 6 inverts once on the cycle after each new qualified read begins, and holds for the rest of that read.
- R6: Outside a busy period, bit 6 never inverts. Successive reads during the settle window return the same bit 6.
- R7: For SETTLE_CYC cycles after `busy` falls, a qualified read returns the true bit 7 of the addressed word, the frozen toggle value on bit 6, and 0 on all other bits. After that window it returns the full stored word.
- R8: At completion, a program writes its word to the target address. A sector erase sets every word whose address agrees with the target above bit SEC_W-1 to 16'hFFFF. A block erase does the same for address bits above BLK_W-1. A chip erase sets every word to 16'hFFFF.
- R9: A start pulse that arrives while busy is ignored. It does not alter the running operation or the array.
- R10: When no qualified read is in progress, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | One-cycle pulse that launches an operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| op_addr | input | AW | Target word, sector or block address |
| op_data | input | DW | Word to program |
| bank_en_n | input | 1 | Flash bank enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Returned read data or status |
| busy | output | 1 | Internal operation in progress |

## Verification
Programs are run with words whose bit 7 is 0 and with words whose bit 7 is 1. This shows whether the polling flag really inverts the pending data rather than forcing a constant. Erases of each size are launched against neighbouring words that were programmed beforehand, and these neighbours separate a correct address-range match from one that is too wide or too narrow. While busy, back-to-back reads, reads with gaps, and strobes with write enable low are all used, so that the toggle is shown to advance only on qualified read starts. Reads placed inside the settle window and just after it confirm when the full word returns.

// File: rtl/flash_eow_status.sv
module flash_eow_status #(
  parameter int AW         = 6,
  parameter int DW         = 16,
  parameter int SEC_W      = 2,
  parameter int BLK_W      = 4,
  parameter int PROG_CYC   = 20,
  parameter int ERASE_CYC  = 40,
  parameter int CHIP_CYC   = 80,
  parameter int SETTLE_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic          bank_en_n,
  input  logic          out_en_n,
  input  logic          wr_en_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  localparam int DEPTH   = 1 << AW;
  localparam int LONGEST = (PROG_CYC > ERASE_CYC)
                           ? ((PROG_CYC > CHIP_CYC) ? PROG_CYC : CHIP_CYC)
                           : ((ERASE_CYC > CHIP_CYC) ? ERASE_CYC : CHIP_CYC);
  localparam int TW = $clog2(LONGEST + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [1:0] K_PROG = 2'b00, K_SEC = 2'b01, K_BLK = 2'b10;

  logic [DW-1:0] mem [DEPTH];
  logic          busy_q, tog_q, rd_q;
  logic [TW-1:0] left_q;
  logic [SW-1:0] settle_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  wire rd_on  = !bank_en_n && !out_en_n && wr_en_n;
  wire accept = op_start && !busy_q;
  wire finish = busy_q && (left_q == TW'(1));

  function automatic logic [TW-1:0] span(input logic [1:0] k);
    case (k)
      K_PROG:       span = TW'(PROG_CYC);
      K_SEC, K_BLK: span = TW'(ERASE_CYC);
      default:      span = TW'(CHIP_CYC);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      left_q   <= '0;
      settle_q <= '0;
      kind_q   <= K_PROG;
      addr_q   <= '0;
      data_q   <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      left_q   <= span(op_kind);
      settle_q <= '0;
      kind_q   <= op_kind;
      addr_q   <= op_addr;
      data_q   <= op_data;
    end else if (busy_q) begin
      left_q <= left_q - TW'(1);
      if (finish) begin
        busy_q   <= 1'b0;
        settle_q <= SW'(SETTLE_CYC);
      end
    end else if (settle_q != '0) begin
      settle_q <= settle_q - SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd_on;
      if (busy_q && rd_on && !rd_q) tog_q <= ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (finish) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [AW-1:0] ia;
        ia = AW'(i);
        case (kind_q)
          K_PROG: if (ia == addr_q) mem[i] <= data_q;
          K_SEC:  if (ia[AW-1:SEC_W] == addr_q[AW-1:SEC_W]) mem[i] <= '1;
          K_BLK:  if (ia[AW-1:BLK_W] == addr_q[AW-1:BLK_W]) mem[i] <= '1;
          default: mem[i] <= '1;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_on) begin
      if (busy_q) begin
        rd_data[7] = (kind_q == K_PROG) ? ~data_q[7] : 1'b0;
        rd_data[6] = tog_q;
      end else if (settle_q != '0) begin
        rd_data[7] = mem[rd_addr][7];
        rd_data[6] = tog_q;
      end else begin
        rd_data = mem[rd_addr];
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/flash_eow_status_chk.sv
module flash_eow_status_chk #(
  parameter int DW        = 16,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40,
  parameter int CHIP_CYC  = 80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_start,
  input logic [1:0]    op_kind,
  input logic [DW-1:0] op_data,
  input logic          bank_en_n,
  input logic          out_en_n,
  input logic          wr_en_n,
  input logic [DW-1:0] rd_data,
  input logic          busy
);
  localparam int LONGEST = (PROG_CYC > ERASE_CYC)
                           ? ((PROG_CYC > CHIP_CYC) ? PROG_CYC : CHIP_CYC)
                           : ((ERASE_CYC > CHIP_CYC) ? ERASE_CYC : CHIP_CYC);
  localparam int LW = $clog2(LONGEST + 2);

  logic          rd_on;
  logic [1:0]    kind_c;
  logic          pbit_c;
  logic [LW-1:0] run_len;

  assign rd_on = !bank_en_n && !out_en_n && wr_en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_c  <= 2'b00;
      pbit_c  <= 1'b0;
      run_len <= '0;
    end else begin
      if (op_start && !busy) begin
        kind_c <= op_kind;
        pbit_c <= op_data[7];
      end
      run_len <= busy ? run_len + LW'(1) : '0;
    end
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_start));
  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_len < LW'(LONGEST));
  // R3
  prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_on && kind_c == 2'b00 |-> rd_data[7] == ~pbit_c);
  // R4
  erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_on && kind_c != 2'b00 |-> !rd_data[7]);
  // R5
  toggle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_on && $past(busy) && $past(rd_on) && !$past(rd_on, 2)
    |-> rd_data[6] != $past(rd_data[6]));
  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_on |-> rd_data == '0);
endmodule

bind flash_eow_status flash_eow_status_chk #(
  .DW(DW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
  .op_data(op_data), .bank_en_n(bank_en_n), .out_en_n(out_en_n),
  .wr_en_n(wr_en_n), .rd_data(rd_data), .busy(busy)
);

// File: tb/test_flash_eow_status.sv
`timescale 1ns/1ps
module test_flash_eow_status;
  localparam int AW = 6, DW = 16, SEC_W = 2, BLK_W = 4;
  localparam int PROG_CYC = 20, ERASE_CYC = 40, CHIP_CYC = 80, SETTLE_CYC = 5;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic op_start = 0;
  logic [1:0] op_kind = 0;
  logic [AW-1:0] op_addr = 0, rd_addr = 0;
  logic [DW-1:0] op_data = 0;
  logic bank_en_n = 1, out_en_n = 1, wr_en_n = 1;
  logic [DW-1:0] rd_data;
  logic busy;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_eow_status #(.AW(AW), .DW(DW), .SEC_W(SEC_W), .BLK_W(BLK_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .CHIP_CYC(CHIP_CYC),
    .SETTLE_CYC(SETTLE_CYC)) i_flash_eow_status (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data), .bank_en_n(bank_en_n),
    .out_en_n(out_en_n), .wr_en_n(wr_en_n), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy));

  // behavioural reference
  int  m_mem [DEPTH];
  int  m_left, m_settle, m_kind, m_addr, m_data;
  bit  m_busy, m_tog, m_rdp;

  function automatic int dur(input int k);
    if (k == 0) return PROG_CYC;
    if (k == 3) return CHIP_CYC;
    return ERASE_CYC;
  endfunction

  task automatic apply_op();
    for (int i = 0; i < DEPTH; i++) begin
      if (m_kind == 0 && i == m_addr) m_mem[i] = m_data;
      if (m_kind == 1 && (i >> SEC_W) == (m_addr >> SEC_W)) m_mem[i] = 16'hFFFF;
      if (m_kind == 2 && (i >> BLK_W) == (m_addr >> BLK_W)) m_mem[i] = 16'hFFFF;
      if (m_kind == 3) m_mem[i] = 16'hFFFF;
    end
  endtask

  always @(posedge clk) begin
    bit rd;
    int exp_v, mask;
    string tag;
    rd = !bank_en_n && !out_en_n && wr_en_n;
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
      m_busy = 0; m_tog = 0; m_rdp = 0; m_left = 0; m_settle = 0;
      m_kind = 0; m_addr = 0; m_data = 0;
    end else begin
      if (m_busy && rd && !m_rdp) m_tog = !m_tog;
      m_rdp = rd;
      if (op_start && !m_busy) begin
        m_busy = 1; m_left = dur(op_kind); m_settle = 0;
        m_kind = op_kind; m_addr = op_addr; m_data = op_data;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; apply_op(); m_settle = SETTLE_CYC; end
      end else if (m_settle > 0) m_settle--;
      #2;
      checks++;
      if (busy !== m_busy) begin
        fails++;
        $display("FAIL R2 busy actual %0b expected %0b", busy, m_busy);
      end
      mask = 16'hFFFF;
      if (!rd) begin exp_v = 0; tag = "R10"; end
      else if (m_busy) begin
        exp_v = ((m_kind == 0) ? ((~m_data) & 16'h80) : 0) | (m_tog ? 16'h40 : 0);
        mask = 16'h00C0;
        tag = (m_kind == 0) ? "R3/R5" : "R4/R5";
      end else if (m_settle > 0) begin
        exp_v = (m_mem[rd_addr] & 16'h80) | (m_tog ? 16'h40 : 0);
        tag = "R7";
      end else begin exp_v = m_mem[rd_addr]; tag = "R8"; end
      checks++;
      if ((int'(rd_data) & mask) != (exp_v & mask) || $isunknown(rd_data)) begin
        fails++;
        $display("FAIL %s rd_data actual %h expected %h (mask %h)", tag, rd_data,
                 exp_v[15:0], mask[15:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic launch(input int k, input int a, input int d);
    @(negedge clk); op_start = 1; op_kind = 2'(k); op_addr = AW'(a); op_data = DW'(d);
    @(negedge clk); op_start = 0;
  endtask

  task automatic rd_word(input int a, output logic [DW-1:0] v);
    @(negedge clk); bank_en_n = 0; out_en_n = 0; wr_en_n = 1; rd_addr = AW'(a);
    @(posedge clk); #3 v = rd_data;
    @(negedge clk); bank_en_n = 1; out_en_n = 1;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic read_back(input int a, input int exp_v, input string tag);
    logic [DW-1:0] v;
    rd_word(a, v);
    chk(v == DW'(exp_v), tag, v, exp_v);
  endtask

  initial begin
    logic [DW-1:0] v1, v2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy", busy, 0);
    read_back(5, 16'hFFFF, "R1");
    read_back(63, 16'hFFFF, "R1");
    // R10 no read strobe
    @(negedge clk); #1 chk(rd_data == 0, "R10", rd_data, 0);

    // program with bit7=0, reads while busy
    launch(0, 5, 16'h1234);
    rd_word(5, v1);
    chk(v1[7] == 1'b1, "R3 poll", v1[7], 1);
    rd_word(5, v2);
    chk(v2[6] != v1[6], "R5 toggle", v2[6], !v1[6]);
    // write strobe is not a qualified read
    @(negedge clk); bank_en_n = 0; out_en_n = 0; wr_en_n = 0;
    @(posedge clk); #3 chk(rd_data == 0, "R10 write strobe", rd_data, 0);
    @(negedge clk); bank_en_n = 1; out_en_n = 1; wr_en_n = 1;
    rd_word(5, v1);
    chk(v1[6] != v2[6], "R5 toggle after write", v1[6], !v2[6]);
    // R9 start during busy
    launch(3, 0, 0);
    measure(n);
    rd_word(5, v1);
    rd_word(5, v2);
    chk(v1 == v2, "R6 settle bit6 frozen", v2, v1);
    chk(v1[7] == 1'b0 && v1[15:8] == 0 && v1[5:0] == 0, "R7 settle", v1, 16'h0000 | v1[6] << 6);
    repeat (SETTLE_CYC) @(negedge clk);
    read_back(5, 16'h1234, "R9 R8 program kept");
    read_back(4, 16'hFFFF, "R9 no chip erase");

    // program with bit7=1, measure length
    launch(0, 6, 16'h0080);
    rd_word(6, v1);
    chk(v1[7] == 1'b0, "R3 poll bit7=1", v1[7], 0);
    measure(n);
    chk(n == PROG_CYC - 2, "R2 program length", n, PROG_CYC - 2);
    repeat (SETTLE_CYC + 1) @(negedge clk);
    read_back(6, 16'h0080, "R8");
    launch(0, 20, 16'hABCD); measure(n);
    chk(n == PROG_CYC, "R2 program length", n, PROG_CYC);
    launch(0, 21, 16'h5A5A); measure(n);
    launch(0, 40, 16'h7777); measure(n);
    repeat (SETTLE_CYC + 1) @(negedge clk);
    read_back(20, 16'hABCD, "R8");

    // sector erase covering 4..7
    launch(1, 5, 0);
    rd_word(5, v1);
    chk(v1[7] == 1'b0, "R4 erase poll", v1[7], 0);
    measure(n);
    chk(n == ERASE_CYC - 2, "R2 erase length", n, ERASE_CYC - 2);
    repeat (SETTLE_CYC + 1) @(negedge clk);
    read_back(5, 16'hFFFF, "R8 sector");
    read_back(6, 16'hFFFF, "R8 sector");
    read_back(20, 16'hABCD, "R8 outside sector");

    // block erase covering 16..31
    launch(2, 16, 0); measure(n);
    chk(n == ERASE_CYC, "R2 block length", n, ERASE_CYC);
    repeat (SETTLE_CYC + 1) @(negedge clk);
    read_back(20, 16'hFFFF, "R8 block");
    read_back(21, 16'hFFFF, "R8 block");
    read_back(40, 16'h7777, "R8 outside block");

    // chip erase
    launch(3, 0, 0); measure(n);
    chk(n == CHIP_CYC, "R2 chip length", n, CHIP_CYC);
    repeat (SETTLE_CYC + 1) @(negedge clk);
    read_back(40, 16'hFFFF, "R8 chip");
    read_back(0, 16'hFFFF, "R8 chip");

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule